// File: doc/BRIEF.md
# AC-link output frame decoder

This block sits on the codec side of an AC'97-style serial link. It runs on the bit clock. It takes the controller's output frame one bit at a time from the serial data line, and the frame marker line delimits each frame. Each frame is 256 bits long and arrives most significant bit first. It holds a 16-bit tag slot and then twelve 20-bit slots. From these the block recovers the per-slot valid tags, the register command in slots 1 and 2, the playback samples in slots 3 to 11, and the GPIO output bits in slot 12.

Register writes leave the block as a one-cycle strobe with its address and data. A write is committed only when every condition below holds in the same frame:
- the frame is marked valid;
- both command slots are tagged valid;
- the command is a write;
- the codec reports ready.

Each playback slot has its own 20-bit output lane and its own one-cycle valid pulse. The GPIO outputs are reloaded at the end of every complete frame. If a new frame marker arrives before the current frame has finished, the unfinished frame is dropped.

Top module: `acl_out_decoder`

## Requirements
- R1: While reset is low, all outputs are zero: the write strobe, the address, the data, every sample lane, every valid flag and the GPIO outputs.
- R2: A frame starts in the cycle where the marker is sampled high after having been sampled low. That cycle carries frame bit 0. Bits arrive MSB first. Frame bit 0 is the frame-valid flag, and frame bit s (s = 1..12) is the valid tag of slot s. Slot s (s >= 1) covers frame bits 16+20(s-1) to 35+20(s-1).
- R3: A write strobe lasts one cycle. It is high in the cycle after the edge that samples frame bit 55, the last bit of slot 2. The address is slot 1 bits 18:12 and the data is slot 2 bits 19:4.
- R4: No write happens unless the slot 1 and slot 2 tags are both 1 in the same frame. A command whose address and data carry their tags in two different frames writes nothing.
- R5: When slot 1 bit 19 is 1 (a read), no strobe is issued and slot 2 is ignored.
- R6: When the ready input is low at the edge that samples frame bit 55, no strobe is issued.
- R7: When the frame is valid and slot k (k = 3..11) is tagged, valid flag k-3 pulses for one cycle after the last bit of the slot. In that cycle, lane k-3 carries all 20 bits of the slot unchanged, including zero padding. A lane that is not tagged keeps its previous value.
- R8: In the cycle after frame bit 255, the GPIO outputs take slot 12 bits 19:10, on every complete frame.
- R9: A marker rising edge before a frame is complete restarts decoding at bit 0. Slots not yet complete produce no strobe, no valid pulse and no GPIO change. This also holds when the edge falls in the same cycle that would have completed a slot.
- R10: When the frame-valid flag is 0, no write strobe and no sample valid pulse occurs, but the GPIO outputs still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame marker; a rising edge starts a frame |
| sdo_i | input | 1 | Serial frame data from the controller |
| codec_rdy_i | input | 1 | Codec ready status; gates register writes |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register write address |
| wr_data_o | output | 16 | Register write data |
| pcm_vld_o | output | 9 | One-cycle valid per playback slot (bit 0 = slot 3) |
| pcm_data_o | output | 180 | Playback lanes, 20 bits each (bits 19:0 = slot 3) |
| gpio_o | output | 10 | GPIO output bits |

## Verification
The tricky overlap is a new frame marker landing on the same edge that would take in the last bit of a slot. Here the frame restart and the slot commit compete for one cycle. The bench provokes this by cutting a fully valid write frame after 55 bits. The next frame's first bit then takes the place of the final bit of slot 2. The bench judges the result by three things: no strobe in the following cycle, no change on any lane or on the GPIO outputs, and a normal write from the frame that follows.

// File: rtl/acl_pkg.sv
package acl_pkg;
  localparam int SLOT_W  = 20;
  localparam int TAG_W   = 16;
  localparam int N_SLOTS = 12;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int GPIO_W  = 10;
  localparam int PCM_LO  = 3;
  localparam int PCM_HI  = 11;
  localparam int WR_SLOT = 2;

  localparam int N_PCM   = PCM_HI - PCM_LO + 1;
  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;
  localparam int POS_W   = $clog2(SLOT_W);
  localparam int SLOT_IW = $clog2(N_SLOTS + 1);
  localparam int KEEP_W  = PCM_HI + 1;   // frame flag plus tags of slots 1..PCM_HI
  localparam int HDR_W   = 1 + ADDR_W;   // read flag plus address

  typedef logic [SLOT_W-1:0]  word_t;
  typedef logic [SLOT_IW-1:0] sidx_t;
endpackage

// File: rtl/acl_deser.sv
module acl_deser
  import acl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              sdo_i,
  output logic              slot_end_o,
  output sidx_t             slot_idx_o,
  output word_t             word_o,
  output logic [KEEP_W-1:0] tags_o
);
  localparam logic [POS_W-1:0] TAG_LAST  = POS_W'(TAG_W - 1);
  localparam logic [POS_W-1:0] WORD_LAST = POS_W'(SLOT_W - 1);
  localparam sidx_t            LAST_SLOT = SLOT_IW'(N_SLOTS);

  logic              sync_q, run_q, run_n;
  logic [POS_W-1:0]  pos_q, pos_n, pos_c, last_pos;
  sidx_t             slot_q, slot_n, slot_c;
  word_t             sh_q, word;
  logic [KEEP_W-1:0] tags_q;
  logic              rise, act, slot_end, tag_en;

  // next state
  always_comb begin
    rise     = sync_i & ~sync_q;
    act      = rise | run_q;
    pos_c    = rise ? '0 : pos_q;
    slot_c   = rise ? '0 : slot_q;
    last_pos = (slot_c == '0) ? TAG_LAST : WORD_LAST;
    slot_end = act & (pos_c == last_pos);
    word     = {sh_q[SLOT_W-2:0], sdo_i};
    tag_en   = slot_end & (slot_c == '0);
    pos_n    = pos_c + 1'b1;
    slot_n   = slot_c;
    run_n    = act;
    if (slot_end) begin
      pos_n  = '0;
      slot_n = slot_c + 1'b1;
      run_n  = (slot_c != LAST_SLOT);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
      pos_q  <= '0;
      slot_q <= '0;
      sh_q   <= '0;
      tags_q <= '0;
    end else begin
      sync_q <= sync_i;
      run_q  <= run_n;
      if (act) begin
        pos_q  <= pos_n;
        slot_q <= slot_n;
        sh_q   <= word;
      end
      if (tag_en) tags_q <= word[TAG_W-1 -: KEEP_W];
    end
  end

  assign slot_end_o = slot_end;
  assign slot_idx_o = slot_c;
  assign word_o     = word;
  assign tags_o     = tags_q;
endmodule

// File: rtl/acl_regwr.sv
module acl_regwr
  import acl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_end_i,
  input  sidx_t             slot_idx_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic              ok1_i,
  input  logic              ok2_i,
  input  logic              codec_rdy_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam sidx_t HDR_SLOT = SLOT_IW'(WR_SLOT - 1);
  localparam sidx_t DAT_SLOT = SLOT_IW'(WR_SLOT);

  logic [HDR_W-1:0]  hdr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              stb_q, hdr_en, dat_hit, go;

  always_comb begin
    hdr_en  = slot_end_i & (slot_idx_i == HDR_SLOT);
    dat_hit = slot_end_i & (slot_idx_i == DAT_SLOT);
    go      = dat_hit & ok1_i & ok2_i & ~hdr_q[HDR_W-1] & codec_rdy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= go;
      if (hdr_en) hdr_q <= hi_i[DATA_W-1 -: HDR_W];
      if (go) begin
        addr_q <= hdr_q[ADDR_W-1:0];
        data_q <= hi_i;
      end
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/acl_slotsink.sv
module acl_slotsink
  import acl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_end_i,
  input  sidx_t                    slot_idx_i,
  input  word_t                    word_i,
  input  logic [N_PCM-1:0]         ok_i,
  output logic [N_PCM-1:0]         pcm_vld_o,
  output logic [N_PCM*SLOT_W-1:0]  pcm_data_o,
  output logic [GPIO_W-1:0]        gpio_o
);
  localparam sidx_t GP_SLOT = SLOT_IW'(N_SLOTS);

  for (genvar k = 0; k < N_PCM; k++) begin : g_lane
    localparam sidx_t MY_SLOT = SLOT_IW'(PCM_LO + k);
    logic  hit, v_q;
    word_t d_q;

    always_comb hit = slot_end_i & (slot_idx_i == MY_SLOT) & ok_i[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= hit;
        if (hit) d_q <= word_i;
      end
    end

    assign pcm_vld_o[k]                   = v_q;
    assign pcm_data_o[k*SLOT_W +: SLOT_W] = d_q;
  end

  logic              gp_en;
  logic [GPIO_W-1:0] gp_q;

  always_comb gp_en = slot_end_i & (slot_idx_i == GP_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gp_q <= '0;
    else if (gp_en) gp_q <= word_i[SLOT_W-1 -: GPIO_W];
  end

  assign gpio_o = gp_q;
endmodule

// File: rtl/acl_out_decoder.sv
module acl_out_decoder
  import acl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_i,
  input  logic                     sdo_i,
  input  logic                     codec_rdy_i,
  output logic                     wr_stb_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic [N_PCM-1:0]         pcm_vld_o,
  output logic [N_PCM*SLOT_W-1:0]  pcm_data_o,
  output logic [GPIO_W-1:0]        gpio_o
);
  logic              slot_end, fv, ok1, ok2;
  sidx_t             slot_idx;
  word_t             word;
  logic [KEEP_W-1:0] tags;
  logic [N_PCM-1:0]  pcm_ok;

  acl_deser u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .sdo_i      (sdo_i),
    .slot_end_o (slot_end),
    .slot_idx_o (slot_idx),
    .word_o     (word),
    .tags_o     (tags)
  );

  // tags[KEEP_W-1] is the frame flag; tags[KEEP_W-1-s] is slot s
  always_comb begin
    fv  = tags[KEEP_W-1];
    ok1 = fv & tags[KEEP_W-1-(WR_SLOT-1)];
    ok2 = fv & tags[KEEP_W-1-WR_SLOT];
    for (int k = 0; k < N_PCM; k++) pcm_ok[k] = fv & tags[KEEP_W-1-(PCM_LO+k)];
  end

  acl_regwr u_regwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_end_i  (slot_end),
    .slot_idx_i  (slot_idx),
    .hi_i        (word[SLOT_W-1 -: DATA_W]),
    .ok1_i       (ok1),
    .ok2_i       (ok2),
    .codec_rdy_i (codec_rdy_i),
    .wr_stb_o    (wr_stb_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o)
  );

  acl_slotsink u_sink (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_end_i (slot_end),
    .slot_idx_i (slot_idx),
    .word_i     (word),
    .ok_i       (pcm_ok),
    .pcm_vld_o  (pcm_vld_o),
    .pcm_data_o (pcm_data_o),
    .gpio_o     (gpio_o)
  );
endmodule

// File: rtl/acl_out_decoder_chk.sv
module acl_out_decoder_chk
  import acl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic              codec_rdy_i,
  input logic              wr_stb_o,
  input logic [N_PCM-1:0]  pcm_vld_o,
  input logic [GPIO_W-1:0] gpio_o
);
  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R6
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(codec_rdy_i));

  // R7
  pcm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pcm_vld_o));

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !$past(sync_i)) |=> (!wr_stb_o && pcm_vld_o == '0));

  // R8
  gpio_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_o) |-> (!wr_stb_o && pcm_vld_o == '0));
endmodule

bind acl_out_decoder acl_out_decoder_chk u_chk (.*);

// File: tb/sim_acl_out_decoder.sv
`timescale 1ns/1ps
module sim_acl_out_decoder;
  import acl_pkg::*;

  logic clk = 1'b0;
  logic rst_n, sync_i, sdo_i, codec_rdy_i;
  logic                    wr_stb_o;
  logic [ADDR_W-1:0]       wr_addr_o;
  logic [DATA_W-1:0]       wr_data_o;
  logic [N_PCM-1:0]        pcm_vld_o;
  logic [N_PCM*SLOT_W-1:0] pcm_data_o;
  logic [GPIO_W-1:0]       gpio_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  word_t             pcm_model [N_PCM];
  logic [GPIO_W-1:0] gpio_model;

  always #5 clk = ~clk;

  acl_out_decoder u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic word_t slot_of(input logic [FRAME_W-1:0] fr, input int s);
    return fr[FRAME_W-1-TAG_W-SLOT_W*(s-1) -: SLOT_W];
  endfunction

  function automatic int slot_last(input int s);
    return TAG_W - 1 + SLOT_W * s;
  endfunction

  function automatic logic [FRAME_W-1:0] build(input logic fv, input logic [N_SLOTS-1:0] tg,
      input logic rw, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
      input logic [GPIO_W-1:0] g);
    logic [FRAME_W-1:0] fr;
    word_t w;
    fr = '0;
    fr[FRAME_W-1 -: TAG_W] = {fv, tg, (TAG_W-1-N_SLOTS)'($urandom)};
    for (int s = 1; s <= N_SLOTS; s++) begin
      w = word_t'($urandom);
      if (s == 1)            w = {rw, a, w[SLOT_W-HDR_W-1:0]};
      else if (s == WR_SLOT) w = {d, w[SLOT_W-DATA_W-1:0]};
      else if (s == N_SLOTS) w = {g, w[SLOT_W-GPIO_W-1:0]};
      fr[FRAME_W-1-TAG_W-SLOT_W*(s-1) -: SLOT_W] = w;
    end
    return fr;
  endfunction

  // Drives len bits of a frame; a full frame is followed by one idle bit.
  task automatic send(input logic [FRAME_W-1:0] fr, input logic rdy, input int len, input string rq);
    logic fv, wcond, exp_stb;
    logic [N_PCM-1:0] exp_v;
    word_t s1, s2;
    int n_stb, jmax, b;
    fv    = fr[FRAME_W-1];
    s1    = slot_of(fr, 1);
    s2    = slot_of(fr, WR_SLOT);
    wcond = fv & fr[FRAME_W-2] & fr[FRAME_W-3] & ~s1[SLOT_W-1] & rdy;
    n_stb = 0;
    jmax  = (len == FRAME_W) ? len : len - 1;
    for (int j = 0; j <= jmax; j++) begin
      @(negedge clk);
      if (j == 0) begin
        // R9: whatever came before left no pending event
        chk("R9", {wr_stb_o, pcm_vld_o}, 0);
        chk("R9", gpio_o, gpio_model);
      end else begin
        b = j - 1;
        exp_stb = (b == slot_last(WR_SLOT)) && wcond;
        if (wr_stb_o || exp_stb) begin
          chk(rq, wr_stb_o, exp_stb);
          if (exp_stb) begin
            chk("R3", wr_addr_o, s1[SLOT_W-2 -: ADDR_W]);
            chk("R3", wr_data_o, s2[SLOT_W-1 -: DATA_W]);
          end
        end
        if (wr_stb_o) n_stb++;
        for (int k = 0; k < N_PCM; k++)
          exp_v[k] = (b == slot_last(PCM_LO+k)) && fv && fr[FRAME_W-1-(PCM_LO+k)];
        if (pcm_vld_o != 0 || exp_v != 0) begin
          chk("R7", pcm_vld_o, exp_v);
          for (int k = 0; k < N_PCM; k++) if (exp_v[k]) begin
            pcm_model[k] = slot_of(fr, PCM_LO+k);
            chk("R7", pcm_data_o[k*SLOT_W +: SLOT_W], pcm_model[k]);
          end
        end
        if (b == FRAME_W - 1) begin
          gpio_model = slot_of(fr, N_SLOTS) >> (SLOT_W - GPIO_W);
          chk("R8", gpio_o, gpio_model);
        end
      end
      if (j < len) begin
        sync_i      = (j < TAG_W);
        sdo_i       = fr[FRAME_W-1-j];
        codec_rdy_i = rdy;
      end else begin
        sync_i = 1'b0;
        sdo_i  = 1'b0;
      end
    end
    chk(rq, n_stb, (wcond && len > slot_last(WR_SLOT)) ? 1 : 0);
    // R7: lanes hold their last tagged value
    for (int k = 0; k < N_PCM; k++) chk("R7", pcm_data_o[k*SLOT_W +: SLOT_W], pcm_model[k]);
  endtask

  initial begin
    logic [FRAME_W-1:0] fr;
    void'($urandom(32'd4294));
    for (int k = 0; k < N_PCM; k++) pcm_model[k] = '0;
    gpio_model  = '0;
    rst_n       = 1'b0;
    sync_i      = 1'b0;
    sdo_i       = 1'b0;
    codec_rdy_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", wr_stb_o, 0);
    chk("R1", wr_addr_o, 0);
    chk("R1", wr_data_o, 0);
    chk("R1", pcm_vld_o, 0);
    chk("R1", |pcm_data_o, 0);
    chk("R1", gpio_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 bit order and slot positions through a known write
    send(build(1'b1, '1, 1'b0, 7'h2A, 16'hBEEF, 10'h155), 1'b1, FRAME_W, "R2");
    chk("R2", wr_addr_o, 7'h2A);
    chk("R2", wr_data_o, 16'hBEEF);
    chk("R2", gpio_o, 10'h155);
    // R5 read command
    send(build(1'b1, '1, 1'b1, 7'h11, 16'h1234, 10'h0AA), 1'b1, FRAME_W, "R5");
    // R4 slot 2 tag clear
    send(build(1'b1, 12'hBFF, 1'b0, 7'h12, 16'h5678, 10'h3FF), 1'b1, FRAME_W, "R4");
    // R6 codec not ready
    send(build(1'b1, '1, 1'b0, 7'h13, 16'h9ABC, 10'h001), 1'b0, FRAME_W, "R6");
    // R10 frame flag clear: no write, no samples, GPIO still moves
    send(build(1'b0, '1, 1'b0, 7'h14, 16'h0F0F, 10'h2C3), 1'b1, FRAME_W, "R10");
    chk("R10", gpio_o, 10'h2C3);
    // R4 address and data tagged in different frames
    send(build(1'b1, 12'h800, 1'b0, 7'h15, 16'h1111, 10'h004), 1'b1, FRAME_W, "R4");
    send(build(1'b1, 12'h400, 1'b0, 7'h15, 16'h1111, 10'h008), 1'b1, FRAME_W, "R4");
    // R7 left-justified 16-bit sample in slot 3 passes through unchanged
    fr = build(1'b1, '1, 1'b1, 7'h00, 16'h0, 10'h010);
    fr[FRAME_W-1-TAG_W-SLOT_W*(PCM_LO-1) -: SLOT_W] = {16'h8001, 4'h0};
    send(fr, 1'b1, FRAME_W, "R7");
    chk("R7", pcm_data_o[SLOT_W-1:0], {16'h8001, 4'h0});
    // R9 restart lands on the last bit of slot 2 of a valid write
    send(build(1'b1, '1, 1'b0, 7'h33, 16'hDEAD, 10'h3C0), 1'b1, slot_last(WR_SLOT), "R9");
    send(build(1'b1, '1, 1'b0, 7'h34, 16'hCAFE, 10'h0F0), 1'b1, FRAME_W, "R9");
    chk("R9", wr_addr_o, 7'h34);
    // R9 restart in the middle of slot 6
    send(build(1'b1, '1, 1'b0, 7'h35, 16'hFACE, 10'h1E1), 1'b1, 130, "R9");
    send(build(1'b1, '1, 1'b0, 7'h36, 16'h0BAD, 10'h2D2), 1'b1, FRAME_W, "R9");
    // R3 random frames
    for (int i = 0; i < 40; i++) begin
      send(build(1'($urandom), N_SLOTS'($urandom), 1'($urandom % 3 == 0), ADDR_W'($urandom),
                 DATA_W'($urandom), GPIO_W'($urandom)), ($urandom % 4) != 0, FRAME_W, "R3");
    end
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule